// File: doc/BRIEF.md
# Bus-Matching Long-Word Read Unpacker

This block sits between the read side of a wide FIFO and a narrower read port. The FIFO always holds full 36-bit long words, made of four 9-bit lanes. The read port is 18 bits wide and runs in one of two sizes. In word mode each long word is delivered as two 18-bit pieces. In byte mode it is delivered as four 9-bit pieces on the low bits of the port. The order of the pieces depends on an endian setting. Big-endian sends the most significant part first. Little-endian sends the least significant part first.

The FIFO presents its head word ahead of the pop. The first read of a long word pops that word, loads the first piece into the output register and keeps the whole word in an auxiliary register. Later reads take their pieces from the auxiliary register and do not touch the FIFO. The FIFO is popped again only after the last piece of the current word has been delivered.

The size and endian inputs are captured on the first clock edge after reset is released. They are then held for the whole of operation. The port reports empty until that capture has taken place.

Top module: `bus_match_unpacker`

## Requirements
- R1: After reset is released, and before the first rising edge that follows, `rd_data` is zero, `rd_empty` is 1 and `fifo_pop` is 0.
- R2: Word mode with big-endian set (`size_byte`=0, `big_endian`=1): a long word {A,B,C,D} is delivered as two reads. Lane A is bits 35:27, B is 26:18, C is 17:9 and D is 8:0. The first read gives A:B (bits 35:18) and the second gives C:D (bits 17:0).
- R3: Word mode with little-endian set (`big_endian`=0): the first read gives C:D and the second gives A:B.
- R4: Byte mode with big-endian set (`size_byte`=1): four reads give lanes A, B, C and D in that order on `rd_data[8:0]`. `rd_data[17:9]` reads as zero.
- R5: Byte mode with little-endian set: four reads give lanes D, C, B and A on `rd_data[8:0]`. Bits 17:9 read as zero.
- R6: `fifo_pop` is asserted only in a cycle in which `rd_en` is 1, `fifo_empty` is 0 and no piece of an earlier word is still pending. The FIFO is popped exactly once per long word.
- R7: `rd_empty` is 0 while pieces of a popped word remain, whatever the state of `fifo_empty`. When no piece is pending, `rd_empty` follows `fifo_empty`.
- R8: A read requested while `rd_empty` is 1 leaves `rd_data` unchanged and causes no pop.
- R9: The endian setting is taken from `big_endian` on the first rising edge after reset release. Later changes of `big_endian` have no effect on the piece order.
- R10: The size setting is taken from `size_byte` on the first rising edge after reset release. Later changes of `size_byte` have no effect.
- R11: While `rd_en` is 0, `rd_data` and the pending piece position hold. Reading resumes with the next piece of the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_data | input | 36 | Head long word of the FIFO, valid while not empty |
| fifo_empty | input | 1 | FIFO holds no long word |
| fifo_pop | output | 1 | Removes the head long word at this rising edge |
| rd_en | input | 1 | Read request from the narrow port |
| size_byte | input | 1 | 1 selects byte mode, 0 selects word mode (captured after reset) |
| big_endian | input | 1 | 1 selects most-significant-first order (captured after reset) |
| rd_data | output | 18 | Output register holding the last delivered piece |
| rd_empty | output | 1 | No piece can be read this cycle |

## Verification
A corrupted piece counter shows up at the port within one read. Pieces would arrive out of order, a lane would repeat, or the FIFO would be popped in the middle of a word. The bench counts pops, so an early or extra pop is caught as soon as the word ends. If the auxiliary register loads at the wrong moment, the second and later pieces of a word would come from the previous word or from the FIFO's next word. The bench sees this on the very next read. A wrong captured configuration changes the order or count of pieces from the first word after reset. The bench flips the configuration inputs after capture so that an unlatched path is exposed at once.

// File: rtl/lwu_pkg.sv
package lwu_pkg;
  typedef struct packed {
    logic byte_mode;
    logic big_end;
  } lwu_cfg_t;

  localparam int unsigned LANES = 4;
endpackage

// File: rtl/lwu_cfg_latch.sv
module lwu_cfg_latch
  import lwu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     size_byte_i,
  input  logic     big_endian_i,
  output lwu_cfg_t cfg_o,
  output logic     cfg_valid_o
);
  lwu_cfg_t cfg_q, cfg_d;
  logic     valid_q, valid_d;
  logic     cap_en;

  assign cap_en = !valid_q;

  always_comb begin
    cfg_d   = cfg_q;
    valid_d = valid_q;
    if (cap_en) begin
      cfg_d.byte_mode = size_byte_i;
      cfg_d.big_end   = big_endian_i;
      valid_d         = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      valid_q <= valid_d;
    end
  end

  assign cfg_o       = cfg_q;
  assign cfg_valid_o = valid_q;
endmodule

// File: rtl/lwu_piece_ctr.sv
module lwu_piece_ctr
  import lwu_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             byte_mode_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(LANES - 1);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(LANES / 2 - 1);

  logic [IDX_W-1:0] idx_q, idx_d, last;

  assign last = byte_mode_i ? LAST_BYTE : LAST_WORD;

  always_comb begin
    idx_d = idx_q;
    if (adv_i) begin
      if (idx_q == last) idx_d = '0;
      else               idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/lwu_lane_sel.sv
module lwu_lane_sel
  import lwu_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [LANES*LANE_W-1:0] word_i,
  input  lwu_cfg_t                cfg_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic [2*LANE_W-1:0]     piece_o
);
  logic [LANE_W-1:0] lane [LANES];
  logic [1:0]        lane_idx;
  logic              upper_half;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = word_i[k*LANE_W +: LANE_W];
  end

  always_comb begin
    lane_idx   = cfg_i.big_end ? (2'd3 - idx_i[1:0]) : idx_i[1:0];
    upper_half = cfg_i.big_end ? !idx_i[0] : idx_i[0];
    if (cfg_i.byte_mode) piece_o = {{LANE_W{1'b0}}, lane[lane_idx]};
    else if (upper_half) piece_o = {lane[3], lane[2]};
    else                 piece_o = {lane[1], lane[0]};
  end
endmodule

// File: rtl/bus_match_unpacker.sv
module bus_match_unpacker
  import lwu_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  localparam int unsigned WORD_W = LANES * LANE_W,
  localparam int unsigned OUT_W  = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  input  logic              rd_en,
  input  logic              size_byte,
  input  logic              big_endian,
  output logic [OUT_W-1:0]  rd_data,
  output logic              rd_empty
);
  localparam int unsigned IDX_W = $clog2(LANES);

  lwu_cfg_t          cfg;
  logic              cfg_valid;
  logic [IDX_W-1:0]  piece_idx;
  logic              pending, rd_fire;
  logic [WORD_W-1:0] aux_q, aux_d, src_word;
  logic [OUT_W-1:0]  out_q, out_d, piece;

  lwu_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n),
    .size_byte_i(size_byte), .big_endian_i(big_endian),
    .cfg_o(cfg), .cfg_valid_o(cfg_valid)
  );

  lwu_piece_ctr #(.IDX_W(IDX_W)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .adv_i(rd_fire), .byte_mode_i(cfg.byte_mode),
    .idx_o(piece_idx)
  );

  lwu_lane_sel #(.LANE_W(LANE_W), .IDX_W(IDX_W)) u_sel (
    .word_i(src_word), .cfg_i(cfg), .idx_i(piece_idx), .piece_o(piece)
  );

  assign pending  = (piece_idx != '0);
  assign rd_empty = !cfg_valid || (!pending && fifo_empty);
  assign rd_fire  = rd_en && !rd_empty;
  assign fifo_pop = rd_fire && !pending;
  assign src_word = pending ? aux_q : fifo_data;

  always_comb begin
    aux_d = aux_q;
    out_d = out_q;
    if (fifo_pop) aux_d = fifo_data;
    if (rd_fire)  out_d = piece;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q <= '0;
      out_q <= '0;
    end else begin
      aux_q <= aux_d;
      out_q <= out_d;
    end
  end

  assign rd_data = out_q;
endmodule

// File: rtl/lwu_checks.sv
module lwu_checks #(
  parameter int unsigned OUT_W = 18,
  parameter int unsigned IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_empty,
  input logic             fifo_pop,
  input logic             rd_en,
  input logic             rd_empty,
  input logic [OUT_W-1:0] rd_data,
  input logic [IDX_W-1:0] piece_idx,
  input logic             cfg_valid,
  input logic             cfg_byte
);
  a_r6_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (rd_en && !fifo_empty));

  a_r6_no_pop_midword: assert property (@(posedge clk) disable iff (!rst_n)
    (piece_idx != '0) |-> !fifo_pop);

  a_r7_pending_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && piece_idx != '0) |-> !rd_empty);

  a_r8_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_empty) |=> $stable(rd_data));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ($stable(rd_data) && $stable(piece_idx)));

  a_r1_empty_before_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> (rd_empty && !fifo_pop));

  a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_empty && cfg_byte) |=> (rd_data[OUT_W-1:OUT_W/2] == '0));
endmodule

bind bus_match_unpacker lwu_checks #(.OUT_W(OUT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
  .rd_en(rd_en), .rd_empty(rd_empty), .rd_data(rd_data),
  .piece_idx(piece_idx), .cfg_valid(cfg_valid), .cfg_byte(cfg.byte_mode)
);

// File: tb/tb_bus_match_unpacker.sv
module tb_bus_match_unpacker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [35:0] fifo_data;
  logic        fifo_empty, fifo_pop, rd_en, size_byte, big_endian, rd_empty;
  logic [17:0] rd_data;

  logic [35:0] mem [64];
  logic [5:0]  wrptr, rdptr;
  int          pops, tests, fails, next_word;
  bit          done;

  always #5 clk = ~clk;

  assign fifo_data  = mem[rdptr];
  assign fifo_empty = (rdptr == wrptr);

  always @(posedge clk) if (rst_n && fifo_pop) begin
    rdptr <= rdptr + 1'b1;
    pops  <= pops + 1;
  end

  bus_match_unpacker dut (
    .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .rd_en(rd_en), .size_byte(size_byte),
    .big_endian(big_endian), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  function automatic logic [35:0] gen_word(int i);
    logic [35:0] w;
    for (int k = 0; k < 4; k++) w[k*9 +: 9] = 9'((i*37 + k*83 + 5) & 511);
    return w;
  endfunction

  function automatic logic [17:0] exp_piece(logic [35:0] w, bit bm, bit be, int p);
    int lane, half;
    if (bm) begin
      lane = be ? 3 - p : p;
      return {9'b0, w[lane*9 +: 9]};
    end
    half = be ? 1 - p : p;
    return w[half*18 +: 18];
  endfunction

  task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(logic [35:0] w);
    mem[wrptr] = w;
    wrptr = wrptr + 1'b1;
  endtask

  task automatic do_reset(bit bm, bit be);
    @(negedge clk);
    rst_n = 1'b0; rd_en = 1'b0; size_byte = bm; big_endian = be;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rd_data", 36'(rd_data), 36'h0);
    check("R1 rd_empty", 36'(rd_empty), 36'h1);
    check("R1 fifo_pop", 36'(fifo_pop), 36'h0);
    @(negedge clk);
    size_byte = !bm; big_endian = !be;
  endtask

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; size_byte = 1'b0; big_endian = 1'b0;
    wrptr = '0; rdptr = '0; pops = 0; tests = 0; fails = 0; next_word = 0; done = 0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int c = 0; c < 4; c++) begin
      bit    bm, be;
      int    np, pops0;
      string tg;
      bm = c[1]; be = c[0];
      np = bm ? 4 : 2;
      tg = bm ? (be ? "R4 R9 R10" : "R5 R9 R10") : (be ? "R2 R9 R10" : "R3 R9 R10");
      do_reset(bm, be);
      pops0 = pops;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check("R8 empty read data", 36'(rd_data), 36'h0);
      check("R8 empty read pop", 36'(pops - pops0), 36'h0);
      for (int w = 0; w < 4; w++) push(gen_word(next_word + w));
      @(negedge clk);
      check("R7 word available", 36'(rd_empty), 36'h0);
      for (int w = 0; w < 4; w++) begin
        for (int p = 0; p < np; p++) begin
          logic [17:0] e;
          e = exp_piece(gen_word(next_word + w), bm, be, p);
          rd_en = 1'b1;
          @(negedge clk);
          if (!be) rd_en = 1'b0;
          check(tg, 36'(rd_data), 36'(e));
          if (w == 1 && p == 0) begin
            rd_en = 1'b0;
            repeat (3) @(negedge clk);
            check("R11 stall data", 36'(rd_data), 36'(e));
            check("R11 stall pending", 36'(rd_empty), 36'h0);
          end
          if (w == 3 && p == 0) check("R7 pending with fifo empty", 36'(rd_empty), 36'h0);
        end
      end
      rd_en = 1'b0;
      check("R7 drained", 36'(rd_empty), 36'h1);
      check("R6 one pop per word", 36'(pops - pops0), 36'd4);
      next_word += 4;
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule